// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank synchronous DRAM command bus. On every rising clock edge it samples the select and row/column/write strobes, the clock-enable level, a two-bit bank number, a 13-bit address and the byte-mask input. It decodes the command, keeps an open or closed flag and an open-row register for each bank, and counts down automatic closes that were requested with an access. It flags commands that break the protocol.

Decoded activity is reported as single-cycle event pulses: read and write burst starts with their column, burst stop, auto refresh, self-refresh entry and mode loads. The block also produces two data-bus enables from the mask input. The write enable follows the mask in the same cycle. The read output enable follows it two clocks later. Its outputs are meant to drive a memory-array model or a protocol monitor. All outputs except the write enable are registered. They show the effect of a command right after the edge that samples it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every bank is closed, `mode_valid` is 0, and `proto_err`, all event pulses and `rd_out_en` are 0.
- R2: With `cs_n` high nothing executes and no error is flagged, whatever the other strobes are. An automatic-close countdown that is already running keeps counting.
- R3: Until the first accepted mode load, every command other than NOP, inhibit and mode load raises `proto_err` for one cycle and is not executed. Strobe codes {cs_n,ras_n,cas_n,we_n} are: 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 burst stop, 0010 PRECHARGE, 0001 refresh, 0000 mode load.
- R4: A mode load with all banks closed and `addr[12]` low sets `mode_valid` and stores `addr[11:0]` in `mode_value`. If any bank is open or `addr[12]` is high, it raises `proto_err` and leaves `mode_value` unchanged.
- R5: ACTIVE to a closed bank opens it. The row from `addr` appears in `open_rows[b*13 +: 13]` for bank b.
- R6: ACTIVE to a bank that is already open raises `proto_err`. That bank's row is left unchanged.
- R7: READ or WRITE to an open bank pulses `ev_read` or `ev_write` and puts `addr[9:0]` on `burst_col`. To a closed bank it raises `proto_err`, gives no event and changes no bank state.
- R8: READ or WRITE with `addr[10]` high closes its bank at the edge BL cycles after the command edge. BL is 1 << `mode_value[1:0]`.
- R9: PRECHARGE with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank, whatever `ba` is.
- R10: The refresh code pulses `ev_auto_ref` when `cke` is high and `ev_self_ref` when `cke` is low.
- R11: The burst-stop code pulses `ev_burst_stop`.
- R12: `wr_data_en` is the inverse of `dqm` in the same cycle. `rd_out_en` is the inverse of the `dqm` value sampled two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable level, selects auto or self refresh |
| ba | input | 2 | Bank number |
| addr | input | 13 | Row, column, control bit 10 or mode value |
| dqm | input | 1 | Data mask, high masks |
| bank_open | output | 4 | One open flag per bank |
| open_rows | output | 52 | Open-row register of each bank, 13 bits per bank |
| mode_valid | output | 1 | A mode value has been accepted |
| mode_value | output | 12 | Last accepted mode value |
| burst_col | output | 10 | Column of the last accepted read or write |
| ev_read | output | 1 | Read burst started |
| ev_write | output | 1 | Write burst started |
| ev_burst_stop | output | 1 | Burst stop decoded |
| ev_auto_ref | output | 1 | Auto refresh decoded |
| ev_self_ref | output | 1 | Self-refresh entry decoded |
| ev_mode_load | output | 1 | Mode value accepted |
| proto_err | output | 1 | Protocol violation in the last sampled command |
| wr_data_en | output | 1 | Write data enable, same cycle |
| rd_out_en | output | 1 | Read output enable, two-cycle latency |

## Verification
The hardest situation to reach is a countdown for an automatic close that runs on while the chip is deselected. It takes a mode load, an ACTIVE and a write with bit 10 set, issued in that order. The stimulus then holds `cs_n` high with the strobes set to the mode-load code, so that a missing select gate would corrupt the mode. The bank is sampled one cycle before and one cycle at the expected close edge. A second mode load with a shorter burst length then repeats the same close for a read.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_ACTIVATE,
        CMD_READ,
        CMD_WRITE,
        CMD_BSTOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_MODE_LOAD
    } cmd_e;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_INHIBIT;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACTIVATE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_BSTOP;
                3'b010:  cmd = CMD_PRECHARGE;
                3'b001:  cmd = CMD_REFRESH;
                default: cmd = CMD_MODE_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
    parameter int ROW_W = 13,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             ap_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CNT_W-1:0] burst_len,
    output logic             is_open,
    output logic [ROW_W-1:0] row
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pre_go) begin
            s_d.open = 1'b0;
            s_d.cnt  = '0;
        end else if (act_go) begin
            s_d.open = 1'b1;
            s_d.row  = row_in;
            s_d.cnt  = '0;
        end else if (ap_go) begin
            s_d.cnt = burst_len;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign is_open = s_q.open;
    assign row     = s_q.row;

    // a bank only closes through a precharge or an expiring countdown
    p_close_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.open) |-> ($past(pre_go) || ($past(s_q.cnt) == CNT_W'(1))));

    // the command checker never reopens an open bank
    p_no_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> !s_q.open);

endmodule

// File: rtl/sdcmd_dq_gate.sv
module sdcmd_dq_gate #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic wr_en,
    output logic rd_en
);

    logic [RD_LAT-1:0] sh_d, sh_q;
    logic [RD_LAT:0]   sh_ext;

    always_comb begin
        sh_ext = {sh_q, dqm};
        sh_d   = sh_ext[RD_LAT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign wr_en = !dqm;
    assign rd_en = !sh_q[RD_LAT-1];

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int COL_W     = 10,
    parameter int AP_BIT    = 10,
    parameter int RD_LAT    = 2,
    parameter int CNT_W     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int MODE_W   = ADDR_W - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        dqm,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
    output logic                        mode_valid,
    output logic [MODE_W-1:0]           mode_value,
    output logic [COL_W-1:0]            burst_col,
    output logic                        ev_read,
    output logic                        ev_write,
    output logic                        ev_burst_stop,
    output logic                        ev_auto_ref,
    output logic                        ev_self_ref,
    output logic                        ev_mode_load,
    output logic                        proto_err,
    output logic                        wr_data_en,
    output logic                        rd_out_en
);

    typedef struct packed {
        logic              mode_ok;
        logic [MODE_W-1:0] mode;
        logic [COL_W-1:0]  col;
        logic              err;
        logic              rd;
        logic              wr;
        logic              bst;
        logic              aref;
        logic              sref;
        logic              lmr;
    } ctl_t;

    ctl_t c_d, c_q;
    cmd_e cmd;

    logic             act_go, ap_go, pre_go, pre_all;
    logic             hit_open, any_open;
    logic [CNT_W-1:0] burst_len;
    logic [NUM_BANKS-1:0] b_act, b_ap, b_pre;

    sdcmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign hit_open  = bank_open[ba];
    assign any_open  = |bank_open;
    assign burst_len = CNT_W'(1) << c_q.mode[1:0];

    always_comb begin
        c_d      = c_q;
        c_d.err  = 1'b0;
        c_d.rd   = 1'b0;
        c_d.wr   = 1'b0;
        c_d.bst  = 1'b0;
        c_d.aref = 1'b0;
        c_d.sref = 1'b0;
        c_d.lmr  = 1'b0;
        act_go   = 1'b0;
        ap_go    = 1'b0;
        pre_go   = 1'b0;
        pre_all  = 1'b0;
        if (cmd == CMD_MODE_LOAD) begin
            if (any_open || addr[ADDR_W-1]) begin
                c_d.err = 1'b1;
            end else begin
                c_d.mode_ok = 1'b1;
                c_d.mode    = addr[MODE_W-1:0];
                c_d.lmr     = 1'b1;
            end
        end else if (cmd != CMD_INHIBIT && cmd != CMD_NOP && !c_q.mode_ok) begin
            c_d.err = 1'b1;
        end else begin
            unique case (cmd)
                CMD_ACTIVATE: begin
                    if (hit_open) c_d.err = 1'b1;
                    else          act_go  = 1'b1;
                end
                CMD_READ, CMD_WRITE: begin
                    if (!hit_open) begin
                        c_d.err = 1'b1;
                    end else begin
                        c_d.rd  = (cmd == CMD_READ);
                        c_d.wr  = (cmd == CMD_WRITE);
                        c_d.col = addr[COL_W-1:0];
                        ap_go   = addr[AP_BIT];
                    end
                end
                CMD_PRECHARGE: begin
                    pre_go  = 1'b1;
                    pre_all = addr[AP_BIT];
                end
                CMD_REFRESH: begin
                    c_d.aref = cke;
                    c_d.sref = !cke;
                end
                CMD_BSTOP: c_d.bst = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign b_act[g] = act_go && (ba == BA_W'(g));
        assign b_ap[g]  = ap_go && (ba == BA_W'(g));
        assign b_pre[g] = pre_go && (pre_all || (ba == BA_W'(g)));

        sdcmd_bank #(
            .ROW_W (ADDR_W),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (b_act[g]),
            .ap_go     (b_ap[g]),
            .pre_go    (b_pre[g]),
            .row_in    (addr),
            .burst_len (burst_len),
            .is_open   (bank_open[g]),
            .row       (open_rows[g*ADDR_W +: ADDR_W])
        );
    end

    sdcmd_dq_gate #(
        .RD_LAT (RD_LAT)
    ) u_dq (
        .clk   (clk),
        .rst_n (rst_n),
        .dqm   (dqm),
        .wr_en (wr_data_en),
        .rd_en (rd_out_en)
    );

    assign mode_valid    = c_q.mode_ok;
    assign mode_value    = c_q.mode;
    assign burst_col     = c_q.col;
    assign proto_err     = c_q.err;
    assign ev_read       = c_q.rd;
    assign ev_write      = c_q.wr;
    assign ev_burst_stop = c_q.bst;
    assign ev_auto_ref   = c_q.aref;
    assign ev_self_ref   = c_q.sref;
    assign ev_mode_load  = c_q.lmr;

    // a mode value is accepted only while every bank was closed
    p_lmr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mode_load |-> ($past(bank_open) == '0));

    // nothing opens and no access or refresh fires before a mode load
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> ((bank_open == '0) && !ev_read && !ev_write &&
                         !ev_auto_ref && !ev_self_ref && !ev_burst_stop));

    // accesses only start while some bank was open
    p_rw_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_read || ev_write) |-> $past(|bank_open));

    // at most one event per cycle
    p_ev_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_read, ev_write, ev_burst_stop, ev_auto_ref, ev_self_ref, ev_mode_load}));

endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke, dqm;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  bank_open;
    logic [51:0] open_rows;
    logic        mode_valid;
    logic [11:0] mode_value;
    logic [9:0]  burst_col;
    logic        ev_read, ev_write, ev_burst_stop, ev_auto_ref, ev_self_ref, ev_mode_load;
    logic        proto_err, wr_data_en, rd_out_en;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    sdram_cmd_tracker uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .cke (cke), .ba (ba), .addr (addr), .dqm (dqm),
        .bank_open (bank_open), .open_rows (open_rows), .mode_valid (mode_valid),
        .mode_value (mode_value), .burst_col (burst_col), .ev_read (ev_read),
        .ev_write (ev_write), .ev_burst_stop (ev_burst_stop), .ev_auto_ref (ev_auto_ref),
        .ev_self_ref (ev_self_ref), .ev_mode_load (ev_mode_load), .proto_err (proto_err),
        .wr_data_en (wr_data_en), .rd_out_en (rd_out_en)
    );

    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                           BST = 4'b0110, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000,
                           INH_LMR = 4'b1000;

    typedef struct packed {
        logic [3:0]  cmd;
        logic        cke;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        err;
        logic [3:0]  open;
    } vec_t;

    localparam vec_t TAB [12] = '{
        '{ACT, 1'b1, 2'd0, 13'h0000, 1'b1, 4'b0000},  // R3 before mode load
        '{LMR, 1'b1, 2'd0, 13'h0022, 1'b0, 4'b0000},  // R4 accepted, BL=4
        '{ACT, 1'b1, 2'd1, 13'h0123, 1'b0, 4'b0010},  // R5
        '{ACT, 1'b1, 2'd1, 13'h0055, 1'b1, 4'b0010},  // R6
        '{RD,  1'b1, 2'd2, 13'h0000, 1'b1, 4'b0010},  // R7 closed bank
        '{ACT, 1'b1, 2'd2, 13'h1ABC, 1'b0, 4'b0110},  // R5
        '{LMR, 1'b1, 2'd0, 13'h0022, 1'b1, 4'b0110},  // R4 banks open
        '{PRE, 1'b1, 2'd2, 13'h0000, 1'b0, 4'b0010},  // R9 single
        '{ACT, 1'b1, 2'd3, 13'h0FFF, 1'b0, 4'b1010},  // R5
        '{PRE, 1'b1, 2'd1, 13'h0400, 1'b0, 4'b0000},  // R9 all
        '{REF, 1'b1, 2'd0, 13'h0000, 1'b0, 4'b0000},  // R10
        '{NOP, 1'b1, 2'd0, 13'h0000, 1'b0, 4'b0000}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic k, input logic [1:0] b,
                         input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        cke  = k;
        ba   = b;
        addr = a;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = NOP;
        cke = 1'b1; ba = 2'd0; addr = '0; dqm = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1 reset state
        check("R1 open", 64'(bank_open), 64'h0);
        check("R1 mode_valid", 64'(mode_valid), 64'h0);
        check("R1 flags", 64'({proto_err, ev_read, ev_write, ev_mode_load, rd_out_en}), 64'h0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            issue(TAB[i].cmd, TAB[i].cke, TAB[i].ba, TAB[i].addr);
            check($sformatf("R3-table err row %0d", i), 64'(proto_err), 64'(TAB[i].err));
            check($sformatf("R5 table open row %0d", i), 64'(bank_open), 64'(TAB[i].open));
            if (i == 10) check("R10 auto ref", 64'(ev_auto_ref), 64'h1);
        end
        check("R4 mode kept", 64'(mode_value), 64'h022);

        // R5 / R6 row register
        issue(ACT, 1'b1, 2'd0, 13'h1555);
        check("R5 row b0", 64'(open_rows[12:0]), 64'h1555);
        issue(ACT, 1'b1, 2'd0, 13'h0AAA);
        check("R6 err", 64'(proto_err), 64'h1);
        check("R6 row kept", 64'(open_rows[12:0]), 64'h1555);

        // R7 accesses
        issue(RD, 1'b1, 2'd0, 13'h02A5);
        check("R7 read event", 64'({ev_read, burst_col}), 64'({1'b1, 10'h2A5}));
        issue(WR, 1'b1, 2'd0, 13'h0133);
        check("R7 write event", 64'({ev_write, burst_col, bank_open[0]}), 64'({1'b1, 10'h133, 1'b1}));
        issue(RD, 1'b1, 2'd3, 13'h0011);
        check("R7 closed bank", 64'({proto_err, ev_read, burst_col, bank_open}),
              64'({1'b1, 1'b0, 10'h133, 4'b0001}));

        // R11 / R10
        issue(BST, 1'b1, 2'd0, 13'h0000);
        check("R11 burst stop", 64'(ev_burst_stop), 64'h1);
        issue(REF, 1'b0, 2'd0, 13'h0000);
        check("R10 self ref", 64'({ev_self_ref, ev_auto_ref}), 64'b10);

        // R8 with R2: write with auto close, BL=4, inhibit cycles in between
        issue(WR, 1'b1, 2'd0, 13'h0400);
        check("R8 open at T", 64'(bank_open[0]), 64'h1);
        issue(INH_LMR, 1'b1, 2'd0, 13'h0FFF);
        check("R2 inhibit no err", 64'(proto_err), 64'h0);
        issue(INH_LMR, 1'b1, 2'd0, 13'h0FFF);
        issue(INH_LMR, 1'b1, 2'd0, 13'h0FFF);
        check("R8 open at T+3", 64'(bank_open[0]), 64'h1);
        issue(INH_LMR, 1'b1, 2'd0, 13'h0FFF);
        check("R8 closed at T+4", 64'(bank_open[0]), 64'h0);
        check("R2 mode untouched", 64'(mode_value), 64'h022);

        // R4 addr[12] high refused, then BL=2 accepted
        issue(LMR, 1'b1, 2'd0, 13'h1031);
        check("R4 bit12 err", 64'({proto_err, mode_value}), 64'({1'b1, 12'h022}));
        issue(LMR, 1'b1, 2'd0, 13'h0031);
        check("R4 accepted", 64'({ev_mode_load, mode_value}), 64'({1'b1, 12'h031}));
        issue(ACT, 1'b1, 2'd1, 13'h0007);
        issue(RD, 1'b1, 2'd1, 13'h0400);
        issue(NOP, 1'b1, 2'd0, 13'h0000);
        check("R8 BL2 open at T+1", 64'(bank_open[1]), 64'h1);
        issue(NOP, 1'b1, 2'd0, 13'h0000);
        check("R8 BL2 closed at T+2", 64'(bank_open[1]), 64'h0);

        // R12 mask timing
        dqm = 1'b0;
        #1;
        check("R12 write same cycle", 64'(wr_data_en), 64'h1);
        issue(NOP, 1'b1, 2'd0, 13'h0000);
        dqm = 1'b1;
        #1;
        check("R12 write masked", 64'(wr_data_en), 64'h0);
        check("R12 read after 1", 64'(rd_out_en), 64'h0);
        issue(NOP, 1'b1, 2'd0, 13'h0000);
        check("R12 read after 2", 64'(rd_out_en), 64'h1);
        issue(NOP, 1'b1, 2'd0, 13'h0000);
        check("R12 read after 3", 64'(rd_out_en), 64'h0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule